// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Unit

This block gathers six interrupt sources for a small 8-bit processor: two external pin events, three events from a 16-bit timer (overflow, compare match, input capture) and the overflow of an 8-bit timer. Each source has a sticky event flag. The flag is set by a one-cycle event pulse from logic outside the block, which already does the edge detection and the timing. Each flag is gated by its own enable bit and by the processor's global interrupt-enable bit. Of the requests that remain, the one with the lowest vector number is presented to the core as a valid signal plus a 3-bit vector number.

A flag clears in one of two ways. The core can acknowledge the presented vector, which clears that vector's flag in the same clock cycle. Software can also write a one to the flag's bit through a simple I/O register port. The flags and enables sit in four 8-bit registers at fixed 6-bit I/O addresses. Register reads are combinational. Writes take effect at the clock edge.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst_n` is low, all four registers read 0x00, `irq_valid` is 0 and `irq_vec` is 0. Reset takes effect at once when `rst_n` falls, and the block leaves reset in step with the clock.
- R2: Register map. Address 0x3A is the external flag register: bit 7 is the external-1 flag and bit 6 is the external-0 flag. Address 0x3B is the external enable register, with the same bit positions. Address 0x39 is the timer enable register: bit 7 is the 16-bit overflow, bit 6 is the compare match, bit 3 is the input capture and bit 1 is the 8-bit overflow. Address 0x38 is the timer flag register, with the same bit positions as 0x39. Every other bit reads 0. Every other address reads 0x00 and ignores writes.
- R3: A one on `src_evt[i]` at a clock edge sets flag i from that edge onward, whatever the enable and global bits are. The bit mapping is: 0 external-0, 1 external-1, 2 input capture, 3 compare match, 4 16-bit overflow, 5 8-bit overflow.
- R4: A source requests an interrupt only when its flag, its enable bit and `gie` are all 1. `irq_valid` is 1 exactly when at least one source requests.
- R5: `irq_vec` is the source index plus one (external-0 is 1 and the 8-bit overflow is 6). When several sources request at once, the lowest vector number is presented. When `irq_valid` is 0, `irq_vec` is 0.
- R6: A write to 0x3A or 0x38 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. These writes never set a flag.
- R7: `irq_ack` high at a clock edge while `irq_valid` is 1 clears only the flag of the vector on `irq_vec`. `irq_ack` while `irq_valid` is 0 changes nothing.
- R8: If an event for a flag arrives at the same edge as an acknowledge or a write-one clear of that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | Write strobe for `io_addr` |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| src_evt | input | 6 | One-cycle event pulses, one bit per source (see R3) |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_valid | output | 1 | An enabled request is pending |
| irq_vec | output | 3 | Vector number of the winning request, 0 when none |

## Verification
The hardest cases to reach from the ports are the same-edge collisions. In these an event pulse meets either an acknowledge or a write-one clear aimed at the very same flag. The bench drives both inputs at one falling edge, so that they are sampled together at the next rising edge. It then reads the flag back to confirm that it survived. Priority is exercised by setting several flags in one pulse and then masking the lower sources one at a time. An acknowledge with no valid request is checked by clearing `gie` while flags are set and reading the flags afterwards.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam int unsigned IO_AW   = 6;
  localparam int unsigned IO_DW   = 8;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned VEC_W   = $clog2(NUM_SRC + 1);

  localparam logic [IO_AW-1:0] ADDR_TMR_FLAG = 6'h38;
  localparam logic [IO_AW-1:0] ADDR_TMR_EN   = 6'h39;
  localparam logic [IO_AW-1:0] ADDR_EXT_FLAG = 6'h3A;
  localparam logic [IO_AW-1:0] ADDR_EXT_EN   = 6'h3B;

  typedef enum logic [1:0] {
    GRP_EXT = 2'd0,
    GRP_TMR = 2'd1
  } reg_grp_e;

  // source index i is presented as vector i+1
  function automatic reg_grp_e src_group(input int unsigned idx);
    return (idx < 2) ? GRP_EXT : GRP_TMR;
  endfunction

  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return 6;
      1:       return 7;
      2:       return 3;
      3:       return 6;
      4:       return 7;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flag_o
);

  logic [NUM-1:0] flag_q;
  logic [NUM-1:0] flag_d;
  logic [NUM-1:0] flag_en;

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    // a new event wins over any clear at the same edge
    always_comb begin
      flag_en[i] = set_i[i] | clr_i[i];
      flag_d[i]  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));  // R3 R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));  // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_o));  // R6

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM = 6,
  parameter int unsigned VW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] req_i,
  output logic           valid_o,
  output logic [VW-1:0]  vec_o,
  output logic [NUM-1:0] grant_o
);

  always_comb begin
    valid_o = 1'b0;
    vec_o   = '0;
    grant_o = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        vec_o   = VW'(i + 1);
        grant_o = NUM'(1) << i;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));  // R5
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((req_i & ((NUM'(1) << (vec_o - 1'b1)) - NUM'(1))) == '0));  // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (vec_o == '0 && req_i == '0));  // R5

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [IO_DW-1:0] io_wdata,
  output logic [IO_DW-1:0] io_rdata,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec
);

  logic               rst_int_n;
  logic [NUM_SRC-1:0] flag;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;
  logic [NUM_SRC-1:0] en_we;
  logic [NUM_SRC-1:0] sw_clr;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic               wr_ext_flag, wr_tmr_flag, wr_ext_en, wr_tmr_en;

  irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    wr_ext_flag = io_wr && (io_addr == ADDR_EXT_FLAG);
    wr_tmr_flag = io_wr && (io_addr == ADDR_TMR_FLAG);
    wr_ext_en   = io_wr && (io_addr == ADDR_EXT_EN);
    wr_tmr_en   = io_wr && (io_addr == ADDR_TMR_EN);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam reg_grp_e GRP = src_group(i);
    localparam int unsigned BP = src_bit(i);

    always_comb begin
      if (GRP == GRP_EXT) begin
        sw_clr[i] = wr_ext_flag & io_wdata[BP];
        en_we[i]  = wr_ext_en;
      end else begin
        sw_clr[i] = wr_tmr_flag & io_wdata[BP];
        en_we[i]  = wr_tmr_en;
      end
      en_d[i] = io_wdata[BP];
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)   en_q[i] <= 1'b0;
      else if (en_we[i]) en_q[i] <= en_d[i];
    end
  end

  irq_flag_bank #(.NUM(NUM_SRC)) i_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (src_evt),
    .clr_i  (sw_clr | ack_clr),
    .flag_o (flag)
  );

  always_comb begin
    req = flag & en_q & {NUM_SRC{gie}};
  end

  irq_prio_enc #(.NUM(NUM_SRC), .VW(VEC_W)) i_prio (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (req),
    .valid_o (irq_valid),
    .vec_o   (irq_vec),
    .grant_o (grant)
  );

  always_comb begin
    ack_clr = irq_ack ? grant : '0;
  end

  // read mux: pack per-source bits into their register slots
  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_group(i) == GRP_EXT) begin
        if (io_addr == ADDR_EXT_FLAG) io_rdata[src_bit(i)] = flag[i];
        if (io_addr == ADDR_EXT_EN)   io_rdata[src_bit(i)] = en_q[i];
      end else begin
        if (io_addr == ADDR_TMR_FLAG) io_rdata[src_bit(i)] = flag[i];
        if (io_addr == ADDR_TMR_EN)   io_rdata[src_bit(i)] = en_q[i];
      end
    end
  end

  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gie |-> !irq_valid);  // R4
  AST_RSVD_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_addr == ADDR_EXT_FLAG || io_addr == ADDR_EXT_EN) |-> (io_rdata[5:0] == '0));  // R2
  AST_RSVD_TMR_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_addr == ADDR_TMR_FLAG || io_addr == ADDR_TMR_EN) |-> ((io_rdata & 8'h35) == '0));  // R2
  AST_NOACK_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack && !irq_valid && !io_wr) |=> ((flag & ~$past(flag)) == $past(src_evt & ~flag)));  // R7

endmodule

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] io_addr;
  logic       io_wr;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic [5:0] src_evt;
  logic       gie;
  logic       irq_ack;
  logic       irq_valid;
  logic [2:0] irq_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .src_evt(src_evt),
    .gie(gie), .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // {ext_en[7:0], tmr_en[7:0], gie, evt[5:0], exp_valid, exp_vec[2:0]}
  localparam int NV = 12;
  localparam logic [26:0] VTBL [NV] = '{
    {8'hC0, 8'h00, 1'b1, 6'b000011, 1'b1, 3'd1},
    {8'h80, 8'h00, 1'b1, 6'b000011, 1'b1, 3'd2},
    {8'h00, 8'hCA, 1'b1, 6'b111100, 1'b1, 3'd3},
    {8'h00, 8'hC2, 1'b1, 6'b111100, 1'b1, 3'd4},
    {8'h00, 8'h82, 1'b1, 6'b110000, 1'b1, 3'd5},
    {8'h00, 8'h02, 1'b1, 6'b110000, 1'b1, 3'd6},
    {8'hC0, 8'hCA, 1'b0, 6'b111111, 1'b0, 3'd0},
    {8'hC0, 8'hCA, 1'b1, 6'b000000, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b1, 6'b111111, 1'b0, 3'd0},
    {8'hC0, 8'hCA, 1'b1, 6'b100000, 1'b1, 3'd6},
    {8'h40, 8'h08, 1'b1, 6'b000110, 1'b1, 3'd3},
    {8'h00, 8'h40, 1'b1, 6'b001000, 1'b1, 3'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic ack_once();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  function automatic logic [7:0] ext_img(input logic [5:0] e);
    return {e[1], e[0], 6'b0};
  endfunction

  function automatic logic [7:0] tmr_img(input logic [5:0] e);
    return {e[4], e[3], 2'b0, e[2], 1'b0, e[5], 1'b0};
  endfunction

  task automatic clear_all();
    wr(6'h3A, 8'hFF);
    wr(6'h38, 8'hFF);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_wdata = '0;
    src_evt = '0; gie = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h3A, d); chk("R1 ext flag", d, 8'h00);
    rd(6'h3B, d); chk("R1 ext en", d, 8'h00);
    rd(6'h39, d); chk("R1 tmr en", d, 8'h00);
    rd(6'h38, d); chk("R1 tmr flag", d, 8'h00);
    chk("R1 valid", irq_valid, 0);
    chk("R1 vec", irq_vec, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table walk: R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      logic [26:0] v;
      v = VTBL[k];
      clear_all();
      wr(6'h3B, v[26:19]);
      wr(6'h39, v[18:11]);
      gie = v[10];
      pulse(v[9:4]);
      chk($sformatf("R4 valid row %0d", k), irq_valid, v[3]);
      chk($sformatf("R5 vec row %0d", k), irq_vec, v[2:0]);
      rd(6'h3A, d); chk($sformatf("R3 ext flags row %0d", k), d, ext_img(v[9:4]));
      rd(6'h38, d); chk($sformatf("R3 tmr flags row %0d", k), d, tmr_img(v[9:4]));
    end

    // R2 reserved bits and unmapped address
    wr(6'h3B, 8'hFF); rd(6'h3B, d); chk("R2 ext en rsvd", d, 8'hC0);
    wr(6'h39, 8'hFF); rd(6'h39, d); chk("R2 tmr en rsvd", d, 8'hCA);
    wr(6'h3C, 8'hFF); rd(6'h3C, d); chk("R2 unmapped", d, 8'h00);

    // R6 write-one clear, zero ignored, never sets
    clear_all(); gie = 1'b0;
    pulse(6'b011111);
    wr(6'h3A, 8'h00); rd(6'h3A, d); chk("R6 zero write", d, 8'hC0);
    wr(6'h3A, 8'h80); rd(6'h3A, d); chk("R6 clear ext1", d, 8'h40);
    wr(6'h38, 8'h08); rd(6'h38, d); chk("R6 clear icap", d, 8'hC0);
    wr(6'h38, 8'h02); rd(6'h38, d); chk("R6 no set", d, 8'hC0);

    // R7 ack while not valid is ignored
    ack_once();
    rd(6'h3A, d); chk("R7 ack idle ext", d, 8'h40);
    rd(6'h38, d); chk("R7 ack idle tmr", d, 8'hC0);

    // R7 ack clears only the presented vector
    clear_all(); wr(6'h3B, 8'hC0); wr(6'h39, 8'h00); gie = 1'b1;
    pulse(6'b000011);
    chk("R7 first vec", irq_vec, 1);
    ack_once();
    chk("R7 after ack vec", irq_vec, 2);
    rd(6'h3A, d); chk("R7 after ack flags", d, 8'h80);
    ack_once();
    chk("R7 after second ack", irq_valid, 0);
    rd(6'h3A, d); chk("R7 all taken", d, 8'h00);

    // R8 event meets ack on same flag
    pulse(6'b000001);
    @(negedge clk);
    irq_ack = 1'b1; src_evt = 6'b000001;
    @(negedge clk);
    irq_ack = 1'b0; src_evt = '0;
    chk("R8 ack+event valid", irq_valid, 1);
    rd(6'h3A, d); chk("R8 ack+event flag", d, 8'h40);

    // R8 event meets write-one clear on same flag
    @(negedge clk);
    io_addr = 6'h3A; io_wdata = 8'h40; io_wr = 1'b1; src_evt = 6'b000001;
    @(negedge clk);
    io_wr = 1'b0; src_evt = '0;
    rd(6'h3A, d); chk("R8 w1c+event flag", d, 8'h40);

    // R1 asynchronous reset mid-run
    pulse(6'b111111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async valid", irq_valid, 0);
    io_addr = 6'h38; #1 chk("R1 async tmr flag", io_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(6'h39, d); chk("R1 after reset tmr en", d, 8'h00);

    done = 1'b1;
    summary();
  end

endmodule